// File: doc/BRIEF.md
# Idle Clock-Slowing Sequencer

This block is the low-power sequencer beside a small processor core. An idle command either parks the core completely (plain idle) or keeps it running from a divided clock enable (slow idle). In slow idle a 2-bit code selects a divide ratio of 16, 32, 64 or 128. The enables for the serial-clock, clock-output and timer domains are derived from the core enable, so they slow down by the same ratio.

An enabled interrupt ends either idle mode, and a one-cycle handoff names the interrupt the core must service first. In plain idle the core restarts on the next cycle. In slow idle the return to full rate waits for the next divided-enable cycle, so the core never sees a partial slow cycle. The wake-up delay therefore depends on where the free-running divider count stands when the interrupt arrives.

Cycle-steal requests from DMA engines are granted in every mode. The gating cells and the interrupt vector logic sit outside this block.

Top module: `lpidle_ctrl`

## Requirements
- R1: A synchronous reset returns the block to run mode with ratio 1. It clears the 7-bit base-cycle counter. While reset is held, and in the cycle after it, core_ce=1, stall=0, svc_valid=0, steal_gnt=0 and the three peripheral enables are 0.
- R2: In run mode core_ce is 1 in every cycle. With the default ratios, clkout_ce pulses on every core cycle, sclk_ce on every 2nd core cycle and timer_ce on every 4th core cycle.
- R3: If idle_req=1 with idle_slow=0 in run mode, then from the next cycle stall=1 and core_ce=0. This holds until an enabled interrupt arrives.
- R4: If idle_req=1 with idle_slow=1 in run mode, the block enters slow idle from the next cycle, with stall=1. Its ratio n comes from idle_div: 00=16, 01=32, 10=64, 11=128. The cycle count c is the number of clock edges since reset was released, taken modulo 128. In slow idle core_ce is 1 exactly in the cycles where c mod n = n-1.
- R5: The peripheral enables pulse only in cycles where core_ce is 1, and keep their per-core-cycle ratios. In slow idle, 4n consecutive cycles therefore hold 4 clkout_ce, 2 sclk_ce and 1 timer_ce pulses.
- R6: In plain idle, an enabled interrupt that is present at a clock edge makes the next cycle a run cycle: stall=0 and core_ce=1.
- R7: In slow idle, even a one-cycle enabled interrupt is remembered. If the interrupt is first seen in a cycle with count c, stall drops after exactly (n-1 - c mod n) + 1 cycles, which is at most n. Full rate (core_ce=1 every cycle) follows from then on.
- R8: An interrupt line wakes the block only when its irq_en bit is 1. Masked interrupts never end either idle mode.
- R9: On every wake-up, svc_valid is 1 for exactly the first run cycle. In that cycle svc_id carries the lowest index among the enabled interrupts seen during the idle period.
- R10: steal_gnt follows steal_req by one cycle, in every mode. It is one-hot and grants the lowest requesting index.
- R11: idle_req is ignored while either idle mode is active. The mode and the ratio stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Idle command strobe |
| idle_slow | input | 1 | 1 = slow idle with a divisor, 0 = plain idle |
| idle_div | input | 2 | Divisor code: 00=16, 01=32, 10=64, 11=128 |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-line enable (1 = unmasked) |
| steal_req | input | NSTEAL | DMA cycle-steal requests |
| core_ce | output | 1 | Core clock enable |
| sclk_ce | output | 1 | Serial-clock domain enable |
| clkout_ce | output | 1 | Clock-output domain enable |
| timer_ce | output | 1 | Timer domain enable |
| stall | output | 1 | High while an idle mode is active |
| svc_valid | output | 1 | One-cycle interrupt-service handoff |
| svc_id | output | IDW | Index of the interrupt to service |
| steal_gnt | output | NSTEAL | One-hot cycle-steal grant |

## Verification
The two functions that can fall in the same cycle are the arrival of a wake interrupt and the divided-enable tick that closes a slow cycle. The bench provokes this by waiting until the base count sits at n-1 for each of the four ratios and pulsing the interrupt in exactly that cycle. It then expects the block to leave idle after a single cycle, with core_ce held high, so that no partial slow cycle is lost.

The other interrupt arrival phases (count 0, 1 and n/2) are judged against the arithmetic latency formula. Steal grants and a re-issued idle command are driven during idle, and the bench confirms that the divided enable pattern stays intact.

// File: rtl/lpidle_pkg.sv
package lpidle_pkg;

  localparam int LP_CNT_W = 7;

  typedef enum logic [1:0] {
    LP_RUN   = 2'd0,
    LP_PLAIN = 2'd1,
    LP_SLOW  = 2'd2
  } lp_mode_e;

  // divisor code -> low-bit mask (n-1) of the free-running counter
  function automatic logic [LP_CNT_W-1:0] lp_code_mask(input logic [1:0] code);
    return LP_CNT_W'((32'd16 << code) - 32'd1);
  endfunction

endpackage

// File: rtl/lpidle_divider.sv
module lpidle_divider
  import lpidle_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                clear,
  input  logic [1:0]          code,
  output logic                tick_now,
  output logic                tick_nxt,
  output logic [LP_CNT_W-1:0] mask_q
);

  logic [LP_CNT_W-1:0] cnt_q;
  logic [LP_CNT_W-1:0] cnt_nxt;
  logic [LP_CNT_W-1:0] mask_nxt;

  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
    if (load)
      mask_nxt = lp_code_mask(code);
    else if (clear)
      mask_nxt = '0;
    else
      mask_nxt = mask_q;
    tick_now = (cnt_q & mask_q) == mask_q;
    tick_nxt = (cnt_nxt & mask_nxt) == mask_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
      mask_q <= mask_nxt;
    end
  end

  // R4: with a ratio above 1 held, a tick is never followed by another tick
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_now && !load && !clear && mask_q != '0) |=> !tick_now);

  // R1: reset restores ratio 1
  assert_ratio_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '0));

endmodule

// File: rtl/lpidle_wake.sv
module lpidle_wake #(
  parameter int NIRQ = 4,
  parameter int IDW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle_act,
  input  logic            take,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            wake_any,
  output logic [IDW-1:0]  wake_id
);

  logic [NIRQ-1:0] pend_q;
  logic [NIRQ-1:0] live;

  always_comb begin
    live     = pend_q | (irq_req & irq_en);
    wake_any = idle_act && (|live);
    wake_id  = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (live[i]) wake_id = IDW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !idle_act || take)
      pend_q <= '0;
    else
      pend_q <= live;
  end

  // R8/R7: an enabled request seen in idle without a wake is remembered
  assert_latch_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    (idle_act && !take && (|(irq_req & irq_en))) |=> (pend_q != '0));

  // R8: nothing masked ever enters the pending set
  assert_masked_kept_out_R8: assert property (@(posedge clk) disable iff (rst)
    ((pend_q == '0) && ((irq_req & irq_en) == '0)) |=> (pend_q == '0));

endmodule

// File: rtl/lpidle_pdiv.sv
module lpidle_pdiv #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic pulse
);

  localparam int W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [W-1:0] LAST = W'(RATIO - 1);

  logic [W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= step && (pc_q == LAST);
      if (step) pc_q <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
    end
  end

  // R5: a domain pulse only ever follows a core step
  assert_pulse_on_step_R5: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(step));

endmodule

// File: rtl/lpidle_steal.sv
module lpidle_steal #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [N-1:0] pick;

  always_comb pick = req & (~req + N'(1));

  always_ff @(posedge clk) begin
    if (rst) gnt <= '0;
    else     gnt <= pick;
  end

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_grant_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (|req) |=> (|gnt));

endmodule

// File: rtl/lpidle_ctrl.sv
module lpidle_ctrl
  import lpidle_pkg::*;
#(
  parameter int NIRQ       = 4,
  parameter int NSTEAL     = 2,
  parameter int SCLK_RATIO = 2,
  parameter int CLKO_RATIO = 1,
  parameter int TMR_RATIO  = 4,
  parameter int IDW        = $clog2(NIRQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  logic              idle_slow,
  input  logic [1:0]        idle_div,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [NIRQ-1:0]   irq_en,
  input  logic [NSTEAL-1:0] steal_req,
  output logic              core_ce,
  output logic              sclk_ce,
  output logic              clkout_ce,
  output logic              timer_ce,
  output logic              stall,
  output logic              svc_valid,
  output logic [IDW-1:0]    svc_id,
  output logic [NSTEAL-1:0] steal_gnt
);

  localparam int NDOM = 3;

  function automatic int dom_ratio(input int idx);
    if (idx == 0) return SCLK_RATIO;
    if (idx == 1) return CLKO_RATIO;
    return TMR_RATIO;
  endfunction

  lp_mode_e            mode_q, mode_nxt;
  logic                div_load, div_clear, go;
  logic                tick_now, tick_nxt, ce_nxt;
  logic [LP_CNT_W-1:0] mask_q;
  logic                wake_any;
  logic [IDW-1:0]      wake_id;
  logic [NDOM-1:0]     dom_ce;
  logic [LP_CNT_W-1:0] lat_q;

  lpidle_divider u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (div_load),
    .clear    (div_clear),
    .code     (idle_div),
    .tick_now (tick_now),
    .tick_nxt (tick_nxt),
    .mask_q   (mask_q)
  );

  lpidle_wake #(.NIRQ(NIRQ), .IDW(IDW)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .idle_act (mode_q != LP_RUN),
    .take     (go),
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .wake_any (wake_any),
    .wake_id  (wake_id)
  );

  lpidle_steal #(.N(NSTEAL)) u_steal (
    .clk (clk),
    .rst (rst),
    .req (steal_req),
    .gnt (steal_gnt)
  );

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    lpidle_pdiv #(.RATIO(dom_ratio(g))) u_pdiv (
      .clk   (clk),
      .rst   (rst),
      .step  (ce_nxt),
      .pulse (dom_ce[g])
    );
  end

  assign sclk_ce   = dom_ce[0];
  assign clkout_ce = dom_ce[1];
  assign timer_ce  = dom_ce[2];

  always_comb begin
    mode_nxt  = mode_q;
    div_load  = 1'b0;
    div_clear = 1'b0;
    go        = 1'b0;
    unique case (mode_q)
      LP_RUN: begin
        if (idle_req) begin
          if (idle_slow) begin
            mode_nxt = LP_SLOW;
            div_load = 1'b1;
          end else begin
            mode_nxt = LP_PLAIN;
          end
        end
      end
      LP_PLAIN: begin
        if (wake_any) begin
          mode_nxt = LP_RUN;
          go       = 1'b1;
        end
      end
      LP_SLOW: begin
        // leave only at the close of a slow cycle
        if (wake_any && tick_now) begin
          mode_nxt  = LP_RUN;
          go        = 1'b1;
          div_clear = 1'b1;
        end
      end
      default: begin
        mode_nxt  = LP_RUN;
        div_clear = 1'b1;
      end
    endcase
    ce_nxt = (mode_nxt != LP_PLAIN) && tick_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= LP_RUN;
      core_ce   <= 1'b1;
      stall     <= 1'b0;
      svc_valid <= 1'b0;
      svc_id    <= '0;
    end else begin
      mode_q    <= mode_nxt;
      core_ce   <= ce_nxt;
      stall     <= (mode_nxt != LP_RUN);
      svc_valid <= go;
      svc_id    <= go ? wake_id : svc_id;
    end
  end

  // cycles spent in slow idle with a wake pending
  always_ff @(posedge clk) begin
    if (rst || !(mode_q == LP_SLOW && wake_any) || go)
      lat_q <= '0;
    else
      lat_q <= lat_q + 1'b1;
  end

  assert_wake_bound_R7: assert property (@(posedge clk) disable iff (rst)
    lat_q <= mask_q);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (core_ce && !stall && !svc_valid));

  assert_plain_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LP_PLAIN && !wake_any) |=> (mode_q == LP_PLAIN && !core_ce));

  assert_domain_in_core_R5: assert property (@(posedge clk) disable iff (rst)
    (sclk_ce || clkout_ce || timer_ce) |-> core_ce);

  assert_svc_single_R9: assert property (@(posedge clk) disable iff (rst)
    svc_valid |=> !svc_valid);

  assert_idle_cmd_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (mode_q != LP_RUN && idle_req && !go) |=> $stable(mode_q) && $stable(mask_q));

endmodule

// File: tb/lpidle_ctrl_bench.sv
module lpidle_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       idle_req, idle_slow;
  logic [1:0] idle_div;
  logic [3:0] irq_req, irq_en;
  logic [1:0] steal_req;
  logic       core_ce, sclk_ce, clkout_ce, timer_ce, stall, svc_valid;
  logic [1:0] svc_id;
  logic [1:0] steal_gnt;

  int errs = 0;
  int nchk = 0;
  int cyc  = 0;
  int wd   = 0;

  always #10 clk = ~clk;

  lpidle_ctrl u_lpidle_ctrl (
    .clk       (clk),
    .rst       (rst),
    .idle_req  (idle_req),
    .idle_slow (idle_slow),
    .idle_div  (idle_div),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .steal_req (steal_req),
    .core_ce   (core_ce),
    .sclk_ce   (sclk_ce),
    .clkout_ce (clkout_ce),
    .timer_ce  (timer_ce),
    .stall     (stall),
    .svc_valid (svc_valid),
    .svc_id    (svc_id),
    .steal_gnt (steal_gnt)
  );

  // base cycles since reset release
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    wd = wd + 1;
    if (wd == 100000) begin
      errs = errs + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog actual=%0d expected=finish", wd);
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      errs = errs + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    int cc, sc, oc, tc, bad, lat, m, n, tgt, idx, c;
    rst = 1'b1; idle_req = 0; idle_slow = 0; idle_div = 0;
    irq_req = 0; irq_en = 0; steal_req = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(core_ce == 1, "R1", "core_ce", core_ce, 1);
    chk(stall == 0 && svc_valid == 0, "R1", "stall|svc", {stall, svc_valid}, 0);
    chk({sclk_ce, clkout_ce, timer_ce} == 0, "R1", "dom_ce", {sclk_ce, clkout_ce, timer_ce}, 0);
    chk(steal_gnt == 0, "R1", "steal_gnt", steal_gnt, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2 full rate
    cc = 0; sc = 0; oc = 0; tc = 0;
    for (int i = 0; i < 16; i++) begin
      cc += core_ce; sc += sclk_ce; oc += clkout_ce; tc += timer_ce;
      @(negedge clk);
    end
    chk(cc == 16, "R2", "core pulses", cc, 16);
    chk(oc == 16, "R2", "clkout pulses", oc, 16);
    chk(sc == 8, "R2", "sclk pulses", sc, 8);
    chk(tc == 4, "R2", "timer pulses", tc, 4);

    // R10 steal in run mode
    steal_req = 2'b11; @(negedge clk);
    chk(steal_gnt == 2'b01, "R10", "gnt both", steal_gnt, 1);
    steal_req = 2'b10; @(negedge clk);
    chk(steal_gnt == 2'b10, "R10", "gnt upper", steal_gnt, 2);
    steal_req = 2'b00; @(negedge clk);
    chk(steal_gnt == 2'b00, "R10", "gnt none", steal_gnt, 0);

    // R3 plain idle
    idle_req = 1; idle_slow = 0; @(negedge clk);
    idle_req = 0;
    chk(stall == 1 && core_ce == 0, "R3", "enter plain", {stall, core_ce}, 2);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (core_ce || sclk_ce || clkout_ce || timer_ce || !stall) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R3", "plain hold", bad, 0);

    // R8 masked lines in plain idle, with a steal (R10)
    irq_en = 4'b0101; irq_req = 4'b1010; bad = 0;
    for (int i = 0; i < 10; i++) begin
      steal_req = (i == 2) ? 2'b10 : 2'b00;
      if (i == 3) chk(steal_gnt == 2'b10, "R10", "gnt in plain idle", steal_gnt, 2);
      if (!stall || core_ce) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8", "masked plain", bad, 0);

    // R11 idle command during plain idle
    idle_req = 1; idle_slow = 1; idle_div = 2'b00; @(negedge clk);
    idle_req = 0; bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (!stall || core_ce) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R11", "plain kept", bad, 0);

    // R6/R9 plain wake
    irq_en = 4'b1100; irq_req = 4'b1100; @(negedge clk);
    irq_req = 4'b0000;
    chk(stall == 0 && core_ce == 1, "R6", "plain wake", {stall, core_ce}, 1);
    chk(svc_valid == 1 && svc_id == 2, "R9", "svc id", svc_id, 2);
    @(negedge clk);
    chk(svc_valid == 0, "R9", "svc single", svc_valid, 0);

    // slow idle sweep: all ratios, four arrival phases each
    irq_en = 4'b1110;
    for (int code = 0; code < 4; code++) begin
      for (int k = 0; k < 4; k++) begin
        n = 16 << code; m = n - 1;
        tgt = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? n / 2 : m;
        idx = 3 - (k % 3);
        irq_req = 4'b0001;  // masked line held throughout (R8)
        idle_req = 1; idle_slow = 1; idle_div = 2'(code); @(negedge clk);
        idle_req = 0;
        chk(stall == 1, "R4", "enter slow", stall, 1);
        cc = 0; sc = 0; oc = 0; tc = 0; bad = 0;
        for (int i = 0; i < 4 * n; i++) begin
          if (core_ce != (((cyc & m) == m) ? 1'b1 : 1'b0)) bad++;
          if (!stall) bad++;
          cc += core_ce; sc += sclk_ce; oc += clkout_ce; tc += timer_ce;
          if (i == 3) chk(steal_gnt == 2'b01, "R10", "gnt in slow idle", steal_gnt, 1);
          idle_req  = (k == 1 && i == 0);
          idle_slow = !(k == 1 && i == 0);
          steal_req = (i == 2) ? 2'b01 : 2'b00;
          @(negedge clk);
        end
        idle_req = 0; idle_slow = 1;
        chk(bad == 0, "R4", "slow pattern", bad, 0);
        chk(cc == 4 && oc == 4, "R5", "core/clkout pulses", cc * 10 + oc, 44);
        chk(sc == 2, "R5", "sclk pulses", sc, 2);
        chk(tc == 1, "R5", "timer pulses", tc, 1);
        while ((cyc & m) != tgt) @(negedge clk);
        c = cyc;
        irq_req = 4'b0001 | (4'b0001 << idx);
        lat = 0;
        do begin
          @(negedge clk);
          irq_req = 4'b0001;
          lat++;
        end while (stall && lat < 300);
        chk(lat == (m - (c & m)) + 1, "R7", "wake latency", lat, (m - (c & m)) + 1);
        chk(lat <= n && core_ce == 1, "R7", "latency bound", lat, n);
        chk(svc_valid == 1 && svc_id == 2'(idx), "R9", "slow svc id", svc_id, idx);
        @(negedge clk);
        chk(svc_valid == 0, "R9", "slow svc single", svc_valid, 0);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
          if (!core_ce || stall) bad++;
          @(negedge clk);
        end
        chk(bad == 0, "R7", "full rate after wake", bad, 0);
        irq_req = 0;
      end
    end

    // R1 reset while in slow idle
    idle_req = 1; idle_slow = 1; idle_div = 2'b11; @(negedge clk);
    idle_req = 0;
    repeat (5) @(negedge clk);
    rst = 1; @(negedge clk);
    chk(stall == 0 && core_ce == 1, "R1", "reset from slow", {stall, core_ce}, 1);
    rst = 0; bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!core_ce || stall) bad++;
    end
    chk(bad == 0, "R1", "ratio 1 after reset", bad, 0);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

endmodule